// File: doc/BRIEF.md
# Dual Sequence Playback Controller

This block schedules the playback of two duty-cycle sequences for a four-channel pulse-width engine. A start pulse for sequence 0 or sequence 1 begins playback. The block then steps a fetch index through the chosen sequence and tells the value decoder which sequence to read. It advances on period-end strobes from the pulse generator. Each value is held for a refresh count of extra periods, or it waits for an explicit step pulse when step-triggered mode is selected. After the last value of a sequence, that value can be held for an end delay of extra periods.

With a nonzero loop count, sequence 0 and sequence 1 are chained and the pair repeats. On the final pass, the refresh and end delay of the last value of sequence 1 are not applied, and a loops-done event is raised at once. A five-bit shortcut mask turns some events directly into stop or start requests. Stop requests take effect only at a period boundary. Every event leaves the block as a single-cycle pulse.

Top module: `seqplay_ctrl`

## Requirements
- R1: After reset, run_o is low, seq_sel_o and fetch_idx_o are 0, and every event output is low.
- R2: A start pulse while idle, for a sequence whose length is nonzero, raises run_o on the next cycle. In that cycle fetch_idx_o is 0, seq_sel_o is the sequence number, and evt_started_o pulses bit 0 for sequence 0 or bit 1 for sequence 1. If both start bits are set, sequence 0 wins.
- R3: In automatic mode (step_mode_i = 0), each value is held for refresh+1 period ends, and then fetch_idx_o increments.
- R4: evt_ended_o pulses bit N in the cycle where fetch_idx_o of sequence N becomes its last index (length-1). This also happens at the start of a length-1 sequence, and it happens on every pass.
- R5: After the last value has played, a nonzero end delay keeps the last index for that many further period ends before the next sequence begins.
- R6: With loops_i nonzero, sequence 0 is followed by sequence 1, and the pair repeats loops_i times. A pass that finishes sequence 1 begins sequence 0 again.
- R7: On the final pass, at the first period end of the last value of sequence 1, the refresh and end-delay settings are skipped and evt_loops_o pulses.
- R8: With loops_i = 0, a started sequence plays once and then holds its last index, with run_o high, until a stop or a start.
- R9: A stop pulse while running takes effect at the next period end. evt_stopped_o then pulses, run_o falls, and the index and select return to 0. A stop pulse while idle pulses evt_stopped_o on the next cycle.
- R10: The shortcut mask bits map as follows. Bit 0: sequence-0 end requests a stop. Bit 1: sequence-1 end requests a stop. Bit 2: loops-done restarts sequence 0. Bit 3: loops-done restarts sequence 1. Bit 4: loops-done requests a stop. A stop that a shortcut requests takes effect at the following period end.
- R11: A start pulse while running is held until the next period end, where playback restarts at index 0 of the requested sequence.
- R12: In step-triggered mode (step_mode_i = 1), the index advances only at a period end that follows a step pulse. Refresh and end delay are ignored.
- R13: A start pulse for a sequence of length 0 is dropped. run_o stays low and no started event pulses.
- R14: evt_period_o pulses once for every period_end_i strobe received while running, and never while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 2 | Start pulse, bit N for sequence N |
| stop_i | input | 1 | Stop pulse |
| step_i | input | 1 | Step pulse for step-triggered mode |
| step_mode_i | input | 1 | 0 automatic refresh advance, 1 step-triggered |
| len0_i | input | LEN_W | Value count of sequence 0 |
| len1_i | input | LEN_W | Value count of sequence 1 |
| refresh0_i | input | CNT_W | Extra periods per value, sequence 0 |
| refresh1_i | input | CNT_W | Extra periods per value, sequence 1 |
| delay0_i | input | CNT_W | End delay in periods, sequence 0 |
| delay1_i | input | CNT_W | End delay in periods, sequence 1 |
| loops_i | input | LOOP_W | Compound pass count, 0 for single playback |
| short_i | input | 5 | Shortcut enable mask |
| period_end_i | input | 1 | Period-end strobe from the pulse generator |
| run_o | output | 1 | Playback active |
| seq_sel_o | output | 1 | Sequence the decoder reads |
| fetch_idx_o | output | LEN_W | Value index the decoder reads |
| evt_started_o | output | 2 | Sequence-started pulses |
| evt_ended_o | output | 2 | Sequence-ended pulses |
| evt_period_o | output | 1 | Period-ended pulse |
| evt_loops_o | output | 1 | Loops-done pulse |
| evt_stopped_o | output | 1 | Stopped pulse |

## Verification
The main playback path is exercised in five configurations:
- A single sequence with a nonzero refresh and no loops. This separates the refresh hold from the index advance, and shows that the last value is held afterwards.
- A two-pass compound run with differing end delays. This shows that the delay counts against the correct sequence and that the pass count is decremented only after sequence 1.
- A final pass whose refresh and delay are both nonzero. This shows that loops-done arrives without those extra periods.
- A step-triggered run. This shows that period ends alone do not advance the index.
- Shortcut runs and a mid-playback restart. These show where stop and start requests take effect relative to the period boundary.

// File: rtl/seqplay_pkg.sv
package seqplay_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PLAY = 2'd1,
        ST_GAP  = 2'd2,
        ST_HOLD = 2'd3
    } play_st_e;

    localparam int unsigned SC_END0_STOP = 0;
    localparam int unsigned SC_END1_STOP = 1;
    localparam int unsigned SC_LOOP_GO0  = 2;
    localparam int unsigned SC_LOOP_GO1  = 3;
    localparam int unsigned SC_LOOP_STOP = 4;
    localparam int unsigned SC_W         = 5;

    localparam int unsigned N_SEQ = 2;

endpackage

// File: rtl/seqplay_pend.sv
module seqplay_pend #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] post_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] req_o
);

    logic [W-1:0] pend_d, pend_q;

    // External requests are visible in the cycle they arrive; internally
    // posted ones only from the next cycle, which keeps loops out.
    always_comb begin
        req_o  = pend_q | set_i;
        pend_d = (req_o & ~clr_i) | post_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

endmodule

// File: rtl/seqplay_core.sv
module seqplay_core
    import seqplay_pkg::*;
#(
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned LOOP_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SEQ-1:0]              req_start_i,
    input  logic                          req_stop_i,
    input  logic                          req_step_i,
    input  logic                          step_mode_i,
    input  logic [N_SEQ-1:0][LEN_W-1:0]   len_i,
    input  logic [N_SEQ-1:0][CNT_W-1:0]   refresh_i,
    input  logic [N_SEQ-1:0][CNT_W-1:0]   delay_i,
    input  logic [LOOP_W-1:0]             loops_i,
    input  logic [SC_W-1:0]               short_i,
    input  logic                          period_end_i,
    output logic [N_SEQ-1:0]              clr_start_o,
    output logic                          clr_stop_o,
    output logic                          clr_step_o,
    output logic                          post_stop_o,
    output logic                          run_o,
    output logic                          seq_sel_o,
    output logic [LEN_W-1:0]              fetch_idx_o,
    output logic [N_SEQ-1:0]              evt_started_o,
    output logic [N_SEQ-1:0]              evt_ended_o,
    output logic                          evt_period_o,
    output logic                          evt_loops_o,
    output logic                          evt_stopped_o
);

    localparam logic [LEN_W-1:0]  L_ONE = LEN_W'(1);
    localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);
    localparam logic [LOOP_W-1:0] P_ONE = LOOP_W'(1);

    typedef struct packed {
        play_st_e              st;
        logic                  sel;
        logic [LEN_W-1:0]      idx;
        logic [CNT_W-1:0]      rep;
        logic [CNT_W-1:0]      gap;
        logic [LOOP_W-1:0]     left;
        logic [N_SEQ-1:0]      ev_start;
        logic [N_SEQ-1:0]      ev_end;
        logic                  ev_period;
        logic                  ev_loops;
        logic                  ev_stop;
    } core_t;

    core_t q, d;

    logic [LEN_W-1:0] cur_len;
    logic             cur_last;
    logic             final_pass;
    logic             go_sel;
    logic             go_ok;
    logic             adv;
    logic             next_seq;
    logic             begin_seq;
    logic             begin_sel;
    logic             begin_reload;
    logic             mark_end;

    always_comb begin
        d             = q;
        d.ev_start    = '0;
        d.ev_end      = '0;
        d.ev_period   = 1'b0;
        d.ev_loops    = 1'b0;
        d.ev_stop     = 1'b0;

        clr_start_o   = '0;
        clr_stop_o    = 1'b0;
        clr_step_o    = !(step_mode_i && (q.st == ST_PLAY)) || period_end_i;
        post_stop_o   = 1'b0;

        cur_len       = len_i[q.sel];
        cur_last      = (q.idx == cur_len - L_ONE);
        final_pass    = (loops_i != '0) && q.sel && (q.left == P_ONE);
        go_sel        = !req_start_i[0];
        go_ok         = (|req_start_i) && (len_i[go_sel] != '0);

        adv           = 1'b0;
        next_seq      = 1'b0;
        begin_seq     = 1'b0;
        begin_sel     = 1'b0;
        begin_reload  = 1'b0;
        mark_end      = 1'b0;

        if (q.st == ST_IDLE) begin
            if (req_stop_i) begin
                clr_stop_o  = 1'b1;
                clr_start_o = '1;
                d.ev_stop   = 1'b1;
            end else if (|req_start_i) begin
                clr_start_o = '1;
                if (go_ok) begin
                    begin_seq    = 1'b1;
                    begin_sel    = go_sel;
                    begin_reload = 1'b1;
                end
            end
        end else if (period_end_i) begin
            d.ev_period = 1'b1;
            if (req_stop_i) begin
                clr_stop_o  = 1'b1;
                clr_start_o = '1;
                d.st        = ST_IDLE;
                d.sel       = 1'b0;
                d.idx       = '0;
                d.rep       = '0;
                d.gap       = '0;
                d.ev_stop   = 1'b1;
            end else if (go_ok) begin
                clr_start_o  = '1;
                begin_seq    = 1'b1;
                begin_sel    = go_sel;
                begin_reload = 1'b1;
            end else begin
                clr_start_o = '1;
                case (q.st)
                    ST_PLAY: begin
                        if (step_mode_i) adv = req_step_i;
                        else             adv = (q.rep == refresh_i[q.sel]) ||
                                               (final_pass && cur_last);
                        if (!adv) begin
                            if (!step_mode_i) d.rep = q.rep + C_ONE;
                        end else if (!cur_last) begin
                            d.idx = q.idx + L_ONE;
                            d.rep = '0;
                            if (q.idx + L_ONE == cur_len - L_ONE) mark_end = 1'b1;
                        end else if (final_pass) begin
                            d.ev_loops = 1'b1;
                            if (short_i[SC_LOOP_STOP]) post_stop_o = 1'b1;
                            if (short_i[SC_LOOP_GO0]) begin
                                begin_seq    = 1'b1;
                                begin_sel    = 1'b0;
                                begin_reload = 1'b1;
                            end else if (short_i[SC_LOOP_GO1]) begin
                                begin_seq    = 1'b1;
                                begin_sel    = 1'b1;
                                begin_reload = 1'b1;
                            end else begin
                                d.st = ST_HOLD;
                            end
                        end else if (!step_mode_i && (delay_i[q.sel] != '0)) begin
                            d.st  = ST_GAP;
                            d.gap = '0;
                        end else begin
                            next_seq = 1'b1;
                        end
                    end
                    ST_GAP: begin
                        if (q.gap == delay_i[q.sel] - C_ONE) next_seq = 1'b1;
                        else                                 d.gap = q.gap + C_ONE;
                    end
                    default: ;
                endcase

                if (next_seq) begin
                    if (loops_i == '0) begin
                        d.st = ST_HOLD;
                    end else if (!q.sel) begin
                        begin_seq = 1'b1;
                        begin_sel = 1'b1;
                    end else begin
                        d.left    = q.left - P_ONE;
                        begin_seq = 1'b1;
                        begin_sel = 1'b0;
                    end
                end
            end
        end

        if (begin_seq) begin
            d.st                  = ST_PLAY;
            d.sel                 = begin_sel;
            d.idx                 = '0;
            d.rep                 = '0;
            d.gap                 = '0;
            d.ev_start[begin_sel] = 1'b1;
            if (begin_reload) d.left = loops_i;
            if (len_i[begin_sel] == L_ONE) mark_end = 1'b1;
        end

        if (mark_end) d.ev_end[d.sel] = 1'b1;

        if ((d.ev_end[0] && short_i[SC_END0_STOP]) ||
            (d.ev_end[1] && short_i[SC_END1_STOP])) begin
            post_stop_o = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        run_o         = (q.st != ST_IDLE);
        seq_sel_o     = q.sel;
        fetch_idx_o   = q.idx;
        evt_started_o = q.ev_start;
        evt_ended_o   = q.ev_end;
        evt_period_o  = q.ev_period;
        evt_loops_o   = q.ev_loops;
        evt_stopped_o = q.ev_stop;
    end

endmodule

// File: rtl/seqplay_ctrl.sv
module seqplay_ctrl
    import seqplay_pkg::*;
#(
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned LOOP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        start_i,
    input  logic              stop_i,
    input  logic              step_i,
    input  logic              step_mode_i,
    input  logic [LEN_W-1:0]  len0_i,
    input  logic [LEN_W-1:0]  len1_i,
    input  logic [CNT_W-1:0]  refresh0_i,
    input  logic [CNT_W-1:0]  refresh1_i,
    input  logic [CNT_W-1:0]  delay0_i,
    input  logic [CNT_W-1:0]  delay1_i,
    input  logic [LOOP_W-1:0] loops_i,
    input  logic [4:0]        short_i,
    input  logic              period_end_i,
    output logic              run_o,
    output logic              seq_sel_o,
    output logic [LEN_W-1:0]  fetch_idx_o,
    output logic [1:0]        evt_started_o,
    output logic [1:0]        evt_ended_o,
    output logic              evt_period_o,
    output logic              evt_loops_o,
    output logic              evt_stopped_o
);

    localparam int unsigned REQ_W = N_SEQ + 2;

    logic [REQ_W-1:0] req_set, req_post, req_clr, req;
    logic [N_SEQ-1:0] clr_start;
    logic             clr_stop, clr_step, post_stop;

    // Request vector layout: [1:0] start, [2] stop, [3] step.
    assign req_set  = {step_i, stop_i, start_i};
    assign req_post = {1'b0, post_stop, {N_SEQ{1'b0}}};
    assign req_clr  = {clr_step, clr_stop, clr_start};

    seqplay_pend #(.W(REQ_W)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (req_set),
        .post_i (req_post),
        .clr_i  (req_clr),
        .req_o  (req)
    );

    seqplay_core #(
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W),
        .LOOP_W (LOOP_W)
    ) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_start_i   (req[N_SEQ-1:0]),
        .req_stop_i    (req[N_SEQ]),
        .req_step_i    (req[N_SEQ+1]),
        .step_mode_i   (step_mode_i),
        .len_i         ({len1_i, len0_i}),
        .refresh_i     ({refresh1_i, refresh0_i}),
        .delay_i       ({delay1_i, delay0_i}),
        .loops_i       (loops_i),
        .short_i       (short_i),
        .period_end_i  (period_end_i),
        .clr_start_o   (clr_start),
        .clr_stop_o    (clr_stop),
        .clr_step_o    (clr_step),
        .post_stop_o   (post_stop),
        .run_o         (run_o),
        .seq_sel_o     (seq_sel_o),
        .fetch_idx_o   (fetch_idx_o),
        .evt_started_o (evt_started_o),
        .evt_ended_o   (evt_ended_o),
        .evt_period_o  (evt_period_o),
        .evt_loops_o   (evt_loops_o),
        .evt_stopped_o (evt_stopped_o)
    );

endmodule

// File: rtl/seqplay_ctrl_chk.sv
module seqplay_ctrl_chk #(
    parameter int unsigned LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             period_end_i,
    input logic [LEN_W-1:0] len0_i,
    input logic [LEN_W-1:0] len1_i,
    input logic             run_o,
    input logic             seq_sel_o,
    input logic [LEN_W-1:0] fetch_idx_o,
    input logic [1:0]       evt_started_o,
    input logic [1:0]       evt_ended_o,
    input logic             evt_period_o,
    input logic             evt_loops_o,
    input logic             evt_stopped_o
);

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_started_o));                                              // R2

    AST_START_INDEX0: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_started_o) |-> (run_o && fetch_idx_o == '0 && seq_sel_o == evt_started_o[1])); // R2

    AST_END0_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ended_o[0] |-> (!seq_sel_o && fetch_idx_o == len0_i - LEN_W'(1)));  // R4

    AST_END1_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ended_o[1] |-> (seq_sel_o && fetch_idx_o == len1_i - LEN_W'(1)));   // R4

    AST_IDX_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_o) && !$past(period_end_i) && run_o) |->
            ($stable(fetch_idx_o) && $stable(seq_sel_o)));                     // R11

    AST_LOOPS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_loops_o |-> ($past(period_end_i) && $past(run_o)));               // R7

    AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stopped_o && $past(run_o)) |-> $past(period_end_i));             // R9

    AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stopped_o |-> !run_o);                                             // R9

    AST_NO_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
        evt_started_o[0] |-> (len0_i != '0));                                  // R13

    AST_PERIOD_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        evt_period_o |-> ($past(period_end_i) && $past(run_o)));              // R14

endmodule

bind seqplay_ctrl seqplay_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .period_end_i  (period_end_i),
    .len0_i        (len0_i),
    .len1_i        (len1_i),
    .run_o         (run_o),
    .seq_sel_o     (seq_sel_o),
    .fetch_idx_o   (fetch_idx_o),
    .evt_started_o (evt_started_o),
    .evt_ended_o   (evt_ended_o),
    .evt_period_o  (evt_period_o),
    .evt_loops_o   (evt_loops_o),
    .evt_stopped_o (evt_stopped_o)
);

// File: tb/seqplay_ctrl_tb.sv
module seqplay_ctrl_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned LEN_W  = 8;
    localparam int unsigned CNT_W  = 8;
    localparam int unsigned LOOP_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        start_i = '0;
    logic              stop_i = 1'b0;
    logic              step_i = 1'b0;
    logic              step_mode_i = 1'b0;
    logic [LEN_W-1:0]  len0_i = '0, len1_i = '0;
    logic [CNT_W-1:0]  refresh0_i = '0, refresh1_i = '0;
    logic [CNT_W-1:0]  delay0_i = '0, delay1_i = '0;
    logic [LOOP_W-1:0] loops_i = '0;
    logic [4:0]        short_i = '0;
    logic              period_end_i = 1'b0;
    logic              run_o, seq_sel_o;
    logic [LEN_W-1:0]  fetch_idx_o;
    logic [1:0]        evt_started_o, evt_ended_o;
    logic              evt_period_o, evt_loops_o, evt_stopped_o;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    seqplay_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W), .LOOP_W(LOOP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .step_i(step_i),
        .step_mode_i(step_mode_i), .len0_i(len0_i), .len1_i(len1_i),
        .refresh0_i(refresh0_i), .refresh1_i(refresh1_i), .delay0_i(delay0_i),
        .delay1_i(delay1_i), .loops_i(loops_i), .short_i(short_i),
        .period_end_i(period_end_i), .run_o(run_o), .seq_sel_o(seq_sel_o),
        .fetch_idx_o(fetch_idx_o), .evt_started_o(evt_started_o),
        .evt_ended_o(evt_ended_o), .evt_period_o(evt_period_o),
        .evt_loops_o(evt_loops_o), .evt_stopped_o(evt_stopped_o)
    );

    task automatic chk(input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // run, sel, idx, started, ended, loops-done, stopped
    task automatic look(input string tag, input int run, input int sel, input int idx,
                        input int st, input int en, input int lp, input int sp);
        chk({tag, " run"},     int'(run_o),         run);
        chk({tag, " sel"},     int'(seq_sel_o),     sel);
        chk({tag, " idx"},     int'(fetch_idx_o),   idx);
        chk({tag, " started"}, int'(evt_started_o), st);
        chk({tag, " ended"},   int'(evt_ended_o),   en);
        chk({tag, " loops"},   int'(evt_loops_o),   lp);
        chk({tag, " stopped"}, int'(evt_stopped_o), sp);
    endtask

    task automatic period();
        period_end_i = 1'b1;
        @(negedge clk);
        period_end_i = 1'b0;
    endtask

    task automatic start(input int s);
        start_i = (s == 0) ? 2'b01 : 2'b10;
        @(negedge clk);
        start_i = '0;
    endtask

    task automatic stop();
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    task automatic step();
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    task automatic cfg(input int l0, input int l1, input int r0, input int r1,
                       input int d0, input int d1, input int lp, input int sc, input int md);
        len0_i = LEN_W'(l0);      len1_i = LEN_W'(l1);
        refresh0_i = CNT_W'(r0);  refresh1_i = CNT_W'(r1);
        delay0_i = CNT_W'(d0);    delay1_i = CNT_W'(d1);
        loops_i = LOOP_W'(lp);    short_i = 5'(sc);
        step_mode_i = md[0];
        @(negedge clk);
    endtask

    task automatic halt(input string tag);
        stop();
        period();
        look({tag, " R9 halt"}, 0, 0, 0, 0, 0, 0, 1);
        @(negedge clk);
    endtask

    task automatic t_reset();
        look("R1 reset", 0, 0, 0, 0, 0, 0, 0);
        chk("R1 reset period", int'(evt_period_o), 0);
    endtask

    task automatic t_single();
        cfg(3, 1, 1, 0, 0, 0, 0, 0, 0);
        start(0);
        look("R2 start0", 1, 0, 0, 1, 0, 0, 0);
        period(); look("R3 p1 refresh", 1, 0, 0, 0, 0, 0, 0);
        chk("R14 period evt", int'(evt_period_o), 1);
        period(); look("R3 p2 advance", 1, 0, 1, 0, 0, 0, 0);
        period(); look("R3 p3 refresh", 1, 0, 1, 0, 0, 0, 0);
        period(); look("R4 p4 last", 1, 0, 2, 0, 1, 0, 0);
        period(); look("R3 p5", 1, 0, 2, 0, 0, 0, 0);
        period(); look("R8 p6 hold", 1, 0, 2, 0, 0, 0, 0);
        period(); look("R8 p7 hold", 1, 0, 2, 0, 0, 0, 0);
        stop();
        look("R9 stop waits boundary", 1, 0, 2, 0, 0, 0, 0);
        period();
        look("R9 stopped", 0, 0, 0, 0, 0, 0, 1);
        chk("R14 period on stop", int'(evt_period_o), 1);
        @(negedge clk);
    endtask

    task automatic t_compound();
        cfg(2, 1, 0, 0, 1, 2, 2, 0, 0);
        start(0);
        look("R6 start0", 1, 0, 0, 1, 0, 0, 0);
        period(); look("R4 c1", 1, 0, 1, 0, 1, 0, 0);
        period(); look("R5 c2 delay0", 1, 0, 1, 0, 0, 0, 0);
        period(); look("R6 c3 seq1", 1, 1, 0, 2, 2, 0, 0);
        period(); look("R5 c4 delay1", 1, 1, 0, 0, 0, 0, 0);
        period(); look("R5 c5 delay1", 1, 1, 0, 0, 0, 0, 0);
        period(); look("R6 c6 pass2", 1, 0, 0, 1, 0, 0, 0);
        period(); look("R4 c7 every pass", 1, 0, 1, 0, 1, 0, 0);
        period(); look("R5 c8", 1, 0, 1, 0, 0, 0, 0);
        period(); look("R6 c9 seq1", 1, 1, 0, 2, 2, 0, 0);
        period(); look("R7 c10 loops done", 1, 1, 0, 0, 0, 1, 0);
        period(); look("R8 c11 hold", 1, 1, 0, 0, 0, 0, 0);
        halt("compound");
    endtask

    task automatic t_final_skip();
        cfg(1, 1, 2, 2, 0, 3, 1, 5'b10000, 0);
        start(0);
        look("R4 f0 len1", 1, 0, 0, 1, 1, 0, 0);
        period(); look("R3 f1", 1, 0, 0, 0, 0, 0, 0);
        period(); look("R3 f2", 1, 0, 0, 0, 0, 0, 0);
        period(); look("R6 f3 seq1", 1, 1, 0, 2, 2, 0, 0);
        period(); look("R7 f4 skip", 1, 1, 0, 0, 0, 1, 0);
        period(); look("R10 loops stop", 0, 0, 0, 0, 0, 0, 1);
        @(negedge clk);
    endtask

    task automatic t_loop_restart();
        cfg(1, 1, 0, 0, 0, 0, 1, 5'b01000, 0);
        start(0);
        look("R2 g0", 1, 0, 0, 1, 1, 0, 0);
        period(); look("R6 g1", 1, 1, 0, 2, 2, 0, 0);
        period(); look("R10 loops go1", 1, 1, 0, 2, 2, 1, 0);
        period(); look("R10 loops go1 again", 1, 1, 0, 2, 2, 1, 0);
        halt("restart1");
    endtask

    task automatic t_end_stop();
        cfg(2, 1, 0, 0, 0, 0, 0, 5'b00001, 0);
        start(0);
        look("R2 e0", 1, 0, 0, 1, 0, 0, 0);
        period(); look("R10 end0 posts stop", 1, 0, 1, 0, 1, 0, 0);
        period(); look("R10 end0 stopped", 0, 0, 0, 0, 0, 0, 1);
        @(negedge clk);
    endtask

    task automatic t_live_start();
        cfg(4, 2, 5, 0, 0, 0, 0, 0, 0);
        start(0);
        period();
        start(1);
        look("R11 start held", 1, 0, 0, 0, 0, 0, 0);
        period();
        look("R11 restart seq1", 1, 1, 0, 2, 0, 0, 0);
        halt("live");
    endtask

    task automatic t_step();
        cfg(3, 1, 3, 0, 4, 0, 0, 0, 1);
        start(0);
        period(); look("R12 no step", 1, 0, 0, 0, 0, 0, 0);
        step();   look("R12 step alone", 1, 0, 0, 0, 0, 0, 0);
        period(); look("R12 advance", 1, 0, 1, 0, 0, 0, 0);
        period(); look("R12 refresh ignored", 1, 0, 1, 0, 0, 0, 0);
        step(); period(); look("R12 last", 1, 0, 2, 0, 1, 0, 0);
        step(); period(); look("R12 delay ignored hold", 1, 0, 2, 0, 0, 0, 0);
        halt("step");
        step_mode_i = 1'b0;
    endtask

    task automatic t_zero_len();
        cfg(0, 1, 0, 0, 0, 0, 0, 0, 0);
        start(0);
        look("R13 empty start", 0, 0, 0, 0, 0, 0, 0);
        period();
        look("R13 still idle", 0, 0, 0, 0, 0, 0, 0);
        chk("R14 idle period", int'(evt_period_o), 0);
        stop();
        look("R9 idle stop", 0, 0, 0, 0, 0, 0, 1);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_compound();
        t_final_skip();
        t_loop_restart();
        t_end_stop();
        t_live_start();
        t_step();
        t_zero_len();
        summary();
        $finish;
    end

endmodule